// File: doc/BRIEF.md
# Bus window chip-select generator

This block watches a multiplexed expansion bus, in which the low address field shares its lines with data and the upper address field has buffered lines of its own. While the address-latch strobe is high it takes the low field into a register, and it freezes that register when the strobe falls. On the falling edge of the strobe it joins the low field with the upper lines and checks whether the access falls in one aligned address window. With the default parameters this window is the 64 KB range 0xE0000 to 0xEFFFF of a 20-bit space.

A hit does not drive the select at once. The access is armed and must wait for a falling edge of a slow peripheral clock that is asynchronous to the system clock. The select then stays on for exactly one slow-clock period, which runs from that falling edge to the next one. For the whole access the block drives three outputs. An external-I/O output turns off the internal data buffers. An active-low acknowledge holds the processor in wait states and is released for one cycle once the select frame has ended.

The slow clock passes through a synchronizer in the system clock domain. The block ignores the bus and drops any access in progress while the bus is granted to another master.

Top module: `bwin_csgen`

## Requirements
- R1: An access is taken only when address bits [ADDR_W-1:WIN_BITS] equal WIN_TAG, where the address is {upper lines, latched low field}. For a miss, cs_en stays 0, ext_io stays 0 and xack_n stays 1.
- R2: The low field is the value on the shared lines at the last clock edge on which the strobe is high. Values placed on those lines after the strobe falls do not change the decode.
- R3: For a hit, ext_io is 1 from the cycle after the strobe-fall edge up to and including the release cycle of xack_n. It returns to 0 on the cycle after that.
- R4: For a hit, xack_n goes to 0 on the cycle after the strobe-fall edge. It stays 0 until the select frame ends, and is then 1 for a release cycle in which ext_io is still 1.
- R5: The select frame starts only at the first synchronized slow-clock falling edge seen after the decode edge. A falling edge detected on the decode edge itself is not used. With SYNC_STAGES flops, a fall on the slow clock input is acted on at the (SYNC_STAGES+1)th rising edge of clk after it.
- R6: cs_en stays 1 for exactly one slow-clock period, from one synchronized falling edge to the next. It goes to 0 on the same edge at which the release cycle begins.
- R7: A strobe pulse that occurs while hold_ack is 1 starts no access, even after hold_ack returns to 0.
- R8: When hold_ack is 1 at a rising edge, all outputs are idle from that edge on (cs_en 0, ext_io 0, xack_n 1), and any access in progress is dropped.
- R9: While rst_n is 0, and after it is released with no bus activity, the outputs are idle (cs_en 0, ext_io 0, xack_n 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad_lo | input | LO_W | Shared low-address/data lines |
| bus_a_hi | input | ADDR_W-LO_W | Buffered upper address lines |
| bus_alat | input | 1 | Address-latch strobe, active high |
| hold_ack | input | 1 | Bus granted to another master; bus lines are not valid |
| pclk_in | input | 1 | Slow peripheral clock, asynchronous to clk |
| cs_en | output | 1 | Chip-select enable, framed by slow-clock falling edges |
| ext_io | output | 1 | Internal data-buffer disable for window accesses |
| xack_n | output | 1 | Active-low acknowledge; low inserts wait states |

## Verification
The bench builds the block with an 8-bit address, a 4-bit latched low field and a 2-bit window, using a tag of 0x2D. The window is then addresses 0xB4 to 0xB7, and the tag comparison reaches into the latched low field. This makes a sweep of all 256 addresses possible, and because the bench puts the inverted low field on the shared lines after the strobe falls, a faulty capture turns up as a missed hit or a false hit. The slow clock has a 12-cycle period that is high for 5 cycles. Hit accesses are started at every one of the 12 phases, so every arming delay is covered, including the case where a falling edge arrives on the decode edge and must be skipped. Expected frame edges are computed from the known falling-edge times plus the synchronizer depth.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_ACT  = 2'd2,
      ST_DONE = 2'd3
   } bwin_state_e;

endpackage

// File: rtl/bwin_sync.sv
module bwin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);

   logic [STAGES-1:0] sr_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sr_q   <= {sr_q[STAGES-2:0], din};
         last_q <= sr_q[STAGES-1];
      end
   end

   assign fall = last_q & ~sr_q[STAGES-1];

endmodule

// File: rtl/bwin_alatch.sv
module bwin_alatch #(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned LO_W     = 8,
   parameter int unsigned WIN_BITS = 16,
   parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = 4'hE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strobe,
   input  logic                   hold,
   input  logic [LO_W-1:0]        ad_lo,
   input  logic [ADDR_W-LO_W-1:0] addr_hi,
   output logic                   dec_stb,
   output logic                   dec_hit
);

   localparam int unsigned HI_W = ADDR_W - LO_W;

   logic            strobe_q;
   logic [LO_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         lo_q     <= '0;
      end else if (hold) begin
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= strobe;
         if (strobe) lo_q <= ad_lo;
      end
   end

   assign dec_stb = strobe_q & ~strobe & ~hold;

   generate
      if (WIN_BITS >= LO_W) begin : g_hi_only
         assign dec_hit = (addr_hi[HI_W-1:WIN_BITS-LO_W] == WIN_TAG);
      end else begin : g_full
         logic [ADDR_W-1:0] full_addr;
         assign full_addr = {addr_hi, lo_q};
         assign dec_hit   = (full_addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
      end
   endgenerate

   // R2
   lo_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!strobe || hold) |-> $stable(lo_q));

endmodule

// File: rtl/bwin_seq.sv
module bwin_seq
   import bwin_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dec_stb,
   input  logic dec_hit,
   input  logic hold,
   input  logic pfall,
   output logic cs_en,
   output logic ext_io,
   output logic xack_n
);

   bwin_state_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else if (hold) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (dec_stb && dec_hit) st_q <= ST_ARM;
            ST_ARM:  if (pfall) st_q <= ST_ACT;
            ST_ACT:  if (pfall) st_q <= ST_DONE;
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_en  = (st_q == ST_ACT);
   assign ext_io = (st_q != ST_IDLE);
   assign xack_n = !((st_q == ST_ARM) || (st_q == ST_ACT));

   // R5
   cs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_en) |-> $past(pfall));

   // R6
   cs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_en) |-> ($past(pfall) || $past(hold)));

   // R4
   cs_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_en |-> !xack_n);

   // R3
   cs_bufoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_en |-> ext_io);

   // R4
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xack_n) |-> (ext_io || $past(hold)));

   // R1
   wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xack_n) |-> $past(dec_stb && dec_hit));

   // R8
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!cs_en && xack_n && !ext_io));

endmodule

// File: rtl/bwin_csgen.sv
module bwin_csgen #(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned LO_W        = 8,
   parameter int unsigned WIN_BITS    = 16,
   parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = 4'hE,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LO_W-1:0]        bus_ad_lo,
   input  logic [ADDR_W-LO_W-1:0] bus_a_hi,
   input  logic                   bus_alat,
   input  logic                   hold_ack,
   input  logic                   pclk_in,
   output logic                   cs_en,
   output logic                   ext_io,
   output logic                   xack_n
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bwin_csgen: SYNC_STAGES must be at least 2");
      end
      if (LO_W < 1 || LO_W >= ADDR_W) begin : g_bad_lo
         $error("bwin_csgen: LO_W must lie in 1..ADDR_W-1");
      end
      if (WIN_BITS < 1 || WIN_BITS >= ADDR_W) begin : g_bad_win
         $error("bwin_csgen: WIN_BITS must lie in 1..ADDR_W-1");
      end
   endgenerate

   logic dec_stb;
   logic dec_hit;
   logic pfall;

   bwin_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pclk_in),
      .fall  (pfall)
   );

   bwin_alatch #(
      .ADDR_W   (ADDR_W),
      .LO_W     (LO_W),
      .WIN_BITS (WIN_BITS),
      .WIN_TAG  (WIN_TAG)
   ) i_alatch (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (bus_alat),
      .hold    (hold_ack),
      .ad_lo   (bus_ad_lo),
      .addr_hi (bus_a_hi),
      .dec_stb (dec_stb),
      .dec_hit (dec_hit)
   );

   bwin_seq i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_stb (dec_stb),
      .dec_hit (dec_hit),
      .hold    (hold_ack),
      .pfall   (pfall),
      .cs_en   (cs_en),
      .ext_io  (ext_io),
      .xack_n  (xack_n)
   );

endmodule

// File: tb/test_bwin_csgen.sv
`timescale 1ns/1ps
module test_bwin_csgen;

   localparam int AW  = 8;
   localparam int LW  = 4;
   localparam int WB  = 2;
   localparam int NS  = 2;
   localparam int PER = 12;
   localparam int HIC = 5;
   localparam int TAGV = 45;
   localparam logic [AW-WB-1:0] TAG = 6'h2D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ale = 1'b0;
   logic hold = 1'b0;
   logic pclk = 1'b0;
   logic [LW-1:0] adl = '0;
   logic [AW-LW-1:0] ah = '0;
   logic cs, eio, xk;
   logic s_cs = 1'b0, s_eio = 1'b0, s_xk = 1'b1;
   int n = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bwin_csgen #(
      .ADDR_W      (AW),
      .LO_W        (LW),
      .WIN_BITS    (WB),
      .WIN_TAG     (TAG),
      .SYNC_STAGES (NS)
   ) i_bwin_csgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_ad_lo (adl),
      .bus_a_hi  (ah),
      .bus_alat  (ale),
      .hold_ack  (hold),
      .pclk_in   (pclk),
      .cs_en     (cs),
      .ext_io    (eio),
      .xack_n    (xk)
   );

   always #2.5 clk = ~clk;

   task automatic tick();
      @(negedge clk);
      n++;
      s_cs  = cs;
      s_eio = eio;
      s_xk  = xk;
      pclk  = ((n % PER) < HIC);
   endtask

   task automatic cmp(input string tag, input bit ecs, input bit eeio, input bit exk);
      checks++;
      if ({s_cs, s_eio, s_xk} !== {ecs, eeio, exk}) begin
         errors++;
         $display("FAIL %s at n=%0d: cs_en/ext_io/xack_n got %b%b%b expected %b%b%b",
                  tag, n, s_cs, s_eio, s_xk, ecs, eeio, exk);
      end
   endtask

   task automatic idle_for(input string tag, input int cnt);
      for (int i = 0; i < cnt; i++) begin
         tick();
         cmp(tag, 1'b0, 1'b0, 1'b1);
      end
   endtask

   // first slow-clock fall that arms an access decoded at edge a+2 (R5)
   function automatic int arm_fall(input int a);
      int f;
      f = a + 2 - NS;
      while ((f % PER) != HIC) f++;
      return f;
   endfunction

   task automatic access(input logic [AW-1:0] addr, input int gap);
      int a, f, f2, last;
      bit hit, ecs, eeio, exk;
      string tg;
      for (int i = 0; i < gap; i++) tick();
      tick();
      a = n;
      ale = 1'b1;
      adl = addr[LW-1:0];
      ah  = addr[AW-1:LW];
      cmp("R1", 1'b0, 1'b0, 1'b1);
      tick();
      ale = 1'b0;
      adl = ~addr[LW-1:0];
      cmp("R1", 1'b0, 1'b0, 1'b1);
      hit = ((int'(addr) / (1 << WB)) == TAGV);
      f = arm_fall(a);
      f2 = f + PER;
      last = f2 + NS + 2;
      while (n < last) begin
         tick();
         ecs  = hit && (n >= f + NS + 1) && (n <= f2 + NS);
         exk  = !(hit && (n >= a + 2) && (n <= f2 + NS));
         eeio = hit && (n >= a + 2) && (n <= f2 + NS + 1);
         if (!hit) tg = "R1 R2";
         else if (s_cs !== ecs) tg = "R5 R6";
         else if (s_xk !== exk) tg = "R4";
         else tg = "R3";
         cmp(tg, ecs, eeio, exk);
      end
   endtask

   initial begin
      // R9: outputs idle during reset
      for (int i = 0; i < 4; i++) begin
         tick();
         cmp("R9", 1'b0, 1'b0, 1'b1);
      end
      rst_n = 1'b1;
      idle_for("R9", PER + 3);

      // R1 R2: every address of the small configuration
      for (int A = 0; A < (1 << AW); A++) access(AW'(A), 0);

      // R5 R6: window hits started at every slow-clock phase
      for (int d = 0; d < PER; d++) access(AW'(TAGV * 4 + (d % 4)), d);

      // R7: strobe while the bus is granted away is ignored
      tick();
      hold = 1'b1;
      ale = 1'b1;
      adl = 4'h5;
      ah  = 4'hB;
      tick();
      ale = 1'b0;
      cmp("R7", 1'b0, 1'b0, 1'b1);
      tick();
      cmp("R7", 1'b0, 1'b0, 1'b1);
      hold = 1'b0;
      idle_for("R7", 2 * PER + NS + 2);

      // R8: hold during an active frame drops the access
      begin
         int a, f;
         tick();
         a = n;
         ale = 1'b1;
         adl = 4'h6;
         ah  = 4'hB;
         tick();
         ale = 1'b0;
         adl = 4'h9;
         f = arm_fall(a);
         while (n < f + NS + 2) tick();
         cmp("R5", 1'b1, 1'b1, 1'b0);
         hold = 1'b1;
         idle_for("R8", 3);
         hold = 1'b0;
         idle_for("R8", 2 * PER);
      end

      // R9: reset in the middle of a frame
      begin
         int a, f;
         tick();
         a = n;
         ale = 1'b1;
         adl = 4'h4;
         ah  = 4'hB;
         tick();
         ale = 1'b0;
         f = arm_fall(a);
         while (n < f + NS + 3) tick();
         cmp("R5", 1'b1, 1'b1, 1'b0);
         rst_n = 1'b0;
         idle_for("R9", 2);
         rst_n = 1'b1;
         idle_for("R9", PER + 3);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired at n=%0d", n);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule